// File: doc/BRIEF.md
# Write-Status Polling Responder

This block stands in for the timing and read-back side of a nonvolatile memory's internal write engine. A one-cycle start pulse launches an operation of one of four kinds (word program, small-region erase, large-region erase, whole-array erase). The block then stays busy for a number of clock cycles that a parameter sets for each kind. While it is busy, a read does not return array contents. It returns a status word instead, and software can poll that word to find out when the operation has finished.

The status word carries two live bits. The poll bit returns the complement of bit 7 of the word being programmed, or reads 0 during any erase. The toggle bit flips on every read. It gives 1 on the first read after an operation starts. The other bits of the status word carry a fixed filler pattern that software must treat as don't-care. Once the operation ends, reads pass the array data through unchanged. The busy flag is also routed out so that a command decoder can refuse new commands while the block is busy.

Top module: `wsp_responder`

## Requirements
- R1: While reset is asserted and directly after it, `busy_o` is 0 and `rd_data_o` is all zeros.
- R2: A start pulse accepted while idle holds `busy_o` high for exactly the cycle count of the selected kind. The kind is taken from `op_i`: 0 is program (PROG_CYC), 1 is small erase (SECT_CYC), 2 is large erase (BLK_CYC) and 3 is whole erase (CHIP_CYC). `busy_o` rises in the cycle after the pulse.
- R3: A start pulse that arrives while `busy_o` is high is ignored. It changes neither the end time nor the kind of the running operation.
- R4: During a program operation, a read returns bit POLL_BIT (7) equal to the inverse of bit 7 of `prog_data_i`, as captured with the start pulse.
- R5: During an erase operation, a read returns 0 on bit POLL_BIT (7).
- R6: While busy, bit TOG_BIT (6) reads 1 on the first read after the operation starts and flips on each further read. Cycles that have no read leave it unchanged.
- R7: While busy, every bit of a read other than bits 7 and 6 equals the same bit of the FILL parameter.
- R8: A read taken while idle returns `array_data_i`. This includes the cycle of the start pulse itself.
- R9: `rd_data_o` is registered. It takes its new value in the cycle after `rd_i` is high and holds its value in every cycle that follows a cycle with `rd_i` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle pulse that starts an internal operation |
| op_i | input | 2 | Kind of operation: 0 program, 1 small erase, 2 large erase, 3 whole erase |
| prog_data_i | input | 16 | Word being programmed; sampled with start_i |
| rd_i | input | 1 | Read strobe |
| array_data_i | input | 16 | Array contents at the read address |
| rd_data_o | output | 16 | Registered read data, either status or array data |
| busy_o | output | 1 | High while an internal operation runs |

## Verification
The bench builds the block with operation lengths of 6, 11, 17 and 23 cycles. At these lengths thousands of operations of every kind fit in a short run, so starts that collide with a busy block and the last cycle of an operation come up many times. The filler pattern is set to 16'h5A3C. This makes the don't-care bits distinct from zero and from the array data. Polling at random densities tests the toggle sequence both with long gaps between reads and with reads on back-to-back cycles.

// File: rtl/wsp_pkg.sv
package wsp_pkg;
    typedef enum logic [1:0] {
        OP_PROG  = 2'd0,
        OP_SECT  = 2'd1,
        OP_BLOCK = 2'd2,
        OP_CHIP  = 2'd3
    } op_e;
endpackage

// File: rtl/wsp_timer.sv
module wsp_timer
    import wsp_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int PROG_CYC = 4,
    parameter int SECT_CYC = 8,
    parameter int BLK_CYC  = 12,
    parameter int CHIP_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  op_e  op_i,
    output logic accept_o,
    output logic busy_o
);
    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;

    function automatic logic [CNT_W-1:0] load_of(op_e o);
        case (o)
            OP_PROG:  return CNT_W'(PROG_CYC - 1);
            OP_SECT:  return CNT_W'(SECT_CYC - 1);
            OP_BLOCK: return CNT_W'(BLK_CYC - 1);
            default:  return CNT_W'(CHIP_CYC - 1);
        endcase
    endfunction

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            if (st_q.cnt == '0) st_d.busy = 1'b0;
            else                st_d.cnt  = st_q.cnt - 1'b1;
        end else if (start_i) begin
            st_d.busy = 1'b1;
            st_d.cnt  = load_of(op_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign accept_o = start_i & ~st_q.busy;
    assign busy_o   = st_q.busy;
endmodule

// File: rtl/wsp_status.sv
module wsp_status #(
    parameter int          DATA_W   = 16,
    parameter int          POLL_BIT = 7,
    parameter int          TOG_BIT  = 6,
    parameter logic [15:0] FILL     = 16'h0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept_i,
    input  logic              is_prog_i,
    input  logic              pbit_i,
    input  logic              busy_i,
    input  logic              rd_i,
    input  logic [DATA_W-1:0] array_i,
    output logic [DATA_W-1:0] rd_data_o
);
    localparam logic [DATA_W-1:0] FILL_W = DATA_W'(FILL);

    typedef struct packed {
        logic              tog;
        logic              prog;
        logic              pbit;
        logic [DATA_W-1:0] rd;
    } sts_t;

    sts_t st_d, st_q;
    logic [DATA_W-1:0] status_word;

    for (genvar b = 0; b < DATA_W; b++) begin : g_word
        if (b == POLL_BIT) begin : g_poll
            assign status_word[b] = st_q.prog & ~st_q.pbit;
        end else if (b == TOG_BIT) begin : g_tog
            assign status_word[b] = st_q.tog;
        end else begin : g_fill
            assign status_word[b] = FILL_W[b];
        end
    end

    always_comb begin
        st_d = st_q;
        if (rd_i) begin
            if (busy_i) begin
                st_d.rd  = status_word;
                st_d.tog = ~st_q.tog;
            end else begin
                st_d.rd  = array_i;
            end
        end
        if (accept_i) begin
            st_d.tog  = 1'b1;
            st_d.prog = is_prog_i;
            st_d.pbit = pbit_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data_o = st_q.rd;
endmodule

// File: rtl/wsp_responder.sv
module wsp_responder
    import wsp_pkg::*;
#(
    parameter int          DATA_W   = 16,
    parameter int          POLL_BIT = 7,
    parameter int          TOG_BIT  = 6,
    parameter logic [15:0] FILL     = 16'h0000,
    parameter int          PROG_CYC = 1250,
    parameter int          SECT_CYC = 500000,
    parameter int          BLK_CYC  = 1250000,
    parameter int          CHIP_CYC = 2500000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        op_i,
    input  logic [DATA_W-1:0] prog_data_i,
    input  logic              rd_i,
    input  logic [DATA_W-1:0] array_data_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              busy_o
);
    localparam int MAX_A   = (PROG_CYC > SECT_CYC) ? PROG_CYC : SECT_CYC;
    localparam int MAX_B   = (BLK_CYC > CHIP_CYC) ? BLK_CYC : CHIP_CYC;
    localparam int MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    op_e  op_sel;
    logic accept;

    assign op_sel = op_e'(op_i);

    wsp_timer #(
        .CNT_W(CNT_W), .PROG_CYC(PROG_CYC), .SECT_CYC(SECT_CYC),
        .BLK_CYC(BLK_CYC), .CHIP_CYC(CHIP_CYC)
    ) timer_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_sel),
        .accept_o(accept), .busy_o(busy_o)
    );

    wsp_status #(
        .DATA_W(DATA_W), .POLL_BIT(POLL_BIT), .TOG_BIT(TOG_BIT), .FILL(FILL)
    ) status_i (
        .clk(clk), .rst_n(rst_n), .accept_i(accept),
        .is_prog_i(op_sel == OP_PROG), .pbit_i(prog_data_i[POLL_BIT]),
        .busy_i(busy_o), .rd_i(rd_i), .array_i(array_data_i),
        .rd_data_o(rd_data_o)
    );
endmodule

// File: rtl/wsp_responder_chk.sv
module wsp_responder_chk #(
    parameter int          DATA_W   = 16,
    parameter int          POLL_BIT = 7,
    parameter int          TOG_BIT  = 6,
    parameter logic [15:0] FILL     = 16'h0000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [1:0]        op_i,
    input logic              rd_i,
    input logic [DATA_W-1:0] array_data_i,
    input logic [DATA_W-1:0] rd_data_o,
    input logic              busy_o
);
    localparam logic [DATA_W-1:0] LIVE_MASK =
        (DATA_W'(1) << POLL_BIT) | (DATA_W'(1) << TOG_BIT);
    localparam logic [DATA_W-1:0] FILL_W = DATA_W'(FILL);

    logic first_q, erase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            first_q <= 1'b0;
            erase_q <= 1'b0;
        end else if (start_i && !busy_o) begin
            first_q <= 1'b1;
            erase_q <= (op_i != 2'd0);
        end else if (rd_i && busy_o) begin
            first_q <= 1'b0;
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> (!busy_o && rd_data_o == '0));

    // R2
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));

    // R5
    erase_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_q && rd_i && busy_o) |=> !rd_data_o[POLL_BIT]);

    // R6
    first_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (first_q && rd_i && busy_o) |=> rd_data_o[TOG_BIT]);

    // R7
    fill_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && busy_o) |=> ((rd_data_o & ~LIVE_MASK) == (FILL_W & ~LIVE_MASK)));

    // R8
    idle_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !busy_o) |=> rd_data_o == $past(array_data_i));

    // R9
    hold_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> $stable(rd_data_o));
endmodule

bind wsp_responder wsp_responder_chk #(
    .DATA_W(DATA_W), .POLL_BIT(POLL_BIT), .TOG_BIT(TOG_BIT), .FILL(FILL)
) chk_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .rd_i(rd_i),
    .array_data_i(array_data_i), .rd_data_o(rd_data_o), .busy_o(busy_o)
);

// File: tb/wsp_responder_tb.sv
module wsp_responder_tb_top;
    localparam int          DW   = 16;
    localparam logic [15:0] FILL = 16'h5A3C;
    localparam int          D0 = 6, D1 = 11, D2 = 17, D3 = 23;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [1:0]    op_i = '0;
    logic [DW-1:0] prog_data_i = '0;
    logic          rd_i = 1'b0;
    logic [DW-1:0] array_data_i = '0;
    logic [DW-1:0] rd_data_o;
    logic          busy_o;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    // model state
    bit            m_busy;
    int            m_rem;
    bit            m_prog, m_pbit, m_tog;
    logic [DW-1:0] m_rd;
    bit            m_fresh;
    bit            m_stat;

    always #4 clk = ~clk;

    wsp_responder #(
        .DATA_W(DW), .POLL_BIT(7), .TOG_BIT(6), .FILL(FILL),
        .PROG_CYC(D0), .SECT_CYC(D1), .BLK_CYC(D2), .CHIP_CYC(D3)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
        .prog_data_i(prog_data_i), .rd_i(rd_i), .array_data_i(array_data_i),
        .rd_data_o(rd_data_o), .busy_o(busy_o)
    );

    function automatic int dur_of(logic [1:0] o);
        case (o)
            2'd0: return D0;
            2'd1: return D1;
            2'd2: return D2;
            default: return D3;
        endcase
    endfunction

    function automatic logic [DW-1:0] status_of(bit prog, bit pbit, bit tog);
        logic [DW-1:0] w;
        w    = FILL;
        w[7] = prog ? ~pbit : 1'b0;
        w[6] = tog;
        return w;
    endfunction

    task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_busy = 0; m_rem = 0; m_prog = 0; m_pbit = 0; m_tog = 0;
        m_rd = '0; m_fresh = 0; m_stat = 0;
    endtask

    // drive inputs, advance one clock, update model, compare at negedge
    task automatic tick(bit s, logic [1:0] o, logic [DW-1:0] pd, bit r, logic [DW-1:0] a);
        start_i = s; op_i = o; prog_data_i = pd; rd_i = r; array_data_i = a;
        @(posedge clk);
        m_fresh = r;
        if (r) begin
            if (m_busy) begin
                m_rd = status_of(m_prog, m_pbit, m_tog);
                m_tog = ~m_tog;
                m_stat = 1;
            end else begin
                m_rd = a;
                m_stat = 0;
            end
        end
        if (m_busy) begin
            if (m_rem == 0) m_busy = 0;
            else m_rem--;
        end else if (s) begin
            m_busy = 1; m_rem = dur_of(o) - 1;
            m_prog = (o == 2'd0); m_pbit = pd[7]; m_tog = 1;
        end
        @(negedge clk);
        check("R2 R3 busy", {15'd0, busy_o}, {15'd0, m_busy});
        if (!m_fresh) check("R9 hold", rd_data_o, m_rd);
        else if (!m_stat) check("R8 idle read", rd_data_o, m_rd);
        else begin
            check(m_prog ? "R4 poll bit" : "R5 poll bit", {15'd0, rd_data_o[7]}, {15'd0, m_rd[7]});
            check("R6 toggle bit", {15'd0, rd_data_o[6]}, {15'd0, m_rd[6]});
            check("R7 filler", rd_data_o & 16'hFF3F, m_rd & 16'hFF3F);
        end
        start_i = 0; rd_i = 0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) tick(0, 0, 0, 0, 16'h1234);
    endtask

    // measure busy length by counting sampled busy cycles
    task automatic measure(logic [1:0] o);
        int len;
        len = 0;
        tick(1, o, 16'h00FF, 0, 0);
        while (busy_o && len < 100) begin
            len++;
            tick(0, 0, 0, 0, 0);
        end
        check("R2 duration", 16'(len), 16'(dur_of(o)));
    endtask

    initial begin
        int unused;
        unused = $urandom(32'd20240607);
        model_reset();
        repeat (3) @(negedge clk);
        check("R1 busy at reset", {15'd0, busy_o}, 16'd0);
        check("R1 data at reset", rd_data_o, 16'd0);
        rst_n = 1;
        idle(2);
        check("R1 after reset", rd_data_o, 16'd0);

        // R2: every operation kind
        for (int k = 0; k < 4; k++) measure(2'(k));

        // R4: program with bit7=1 then bit7=0, repeated polling
        tick(1, 0, 16'h0080, 0, 0);
        for (int i = 0; i < 4; i++) tick(0, 0, 0, 1, 16'hFFFF);
        check("R4 poll inverted of 1", {15'd0, rd_data_o[7]}, 16'd0);
        idle(4);
        tick(1, 0, 16'hFF7F, 1, 16'hBEEF);
        check("R8 read on start cycle", rd_data_o, 16'hBEEF);
        tick(0, 0, 0, 1, 0);
        check("R6 first read is one", {15'd0, rd_data_o[6]}, 16'd1);
        check("R4 poll inverted of 0", {15'd0, rd_data_o[7]}, 16'd1);
        idle(3);
        check("R6 no read keeps value", {15'd0, rd_data_o[6]}, 16'd1);
        tick(0, 0, 0, 1, 0);
        check("R6 second read is zero", {15'd0, rd_data_o[6]}, 16'd0);
        idle(4);

        // R3/R5: erase, start during busy ignored
        tick(1, 3, 16'h0000, 0, 0);
        tick(1, 0, 16'h0000, 1, 0);
        check("R5 erase poll zero", {15'd0, rd_data_o[7]}, 16'd0);
        check("R7 filler in erase", rd_data_o & 16'hFF3F, FILL & 16'hFF3F);
        for (int i = 0; i < D3 - 2; i++) tick(1, 0, 0, 0, 0);
        check("R3 still busy at end", {15'd0, busy_o}, 16'd1);
        tick(0, 0, 0, 0, 0);
        check("R3 ends on own length", {15'd0, busy_o}, 16'd0);
        tick(0, 0, 0, 1, 16'hC001);
        check("R8 array after end", rd_data_o, 16'hC001);

        // random traffic
        for (int i = 0; i < 4000; i++) begin
            int dens;
            dens = (i < 2000) ? 2 : 6;
            tick(($urandom % 8) == 0, 2'($urandom), 16'($urandom),
                 ($urandom % dens) == 0, 16'($urandom));
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule